// File: doc/BRIEF.md
# UART Receive/Transmit FIFO and Interrupt Status Unit

This block sits between a UART's serial shifters and the host register interface. It holds a 16-entry receive queue and an 8-entry transmit queue. Every received character is stored with its own break, framing, parity and overrun tags, so the error state that the host reads always belongs to the character at the head of the queue. The block also derives the receive and transmit trigger-level interrupts and a receive idle timeout. It keeps these three conditions as sticky status bits and combines them into one interrupt line.

The receive shifter presents a character together with its error bits on `rx_push`. The transmit shifter takes characters with `tx_pop`. The host pops received data and pushes transmit data. It also writes three registers, selected by `reg_sel`: FIFO control (0), interrupt enable (1) and status clear (2). The status word, the FIFO control readback and the transmit fill count are always visible on output ports. Serial shifting is done elsewhere. A `char_tick` pulse, supplied once per character time, measures receive idleness.

Top module: `uart_fifo_irq_unit`

## Requirements
- R1: After reset, `status` is 16'h4000 (receive queue empty), `fifo_ctrl` is 0, `tx_count` is 0 and `irq` is 0.
- R2: The receive queue keeps first-in first-out order for up to 16 entries. `rx_data` shows the head character, and `status[4:0]` gives the receive fill count one cycle after each push or pop. A pop on an empty queue has no effect.
- R3: `status` carries the head character's tags: bit 15 break, bit 13 framing, bit 12 parity, bit 11 overrun. Bit 14 is 1 exactly when the receive queue is empty. While the queue is empty, the tag bits read 0.
- R4: A push into a full receive queue with no pop in the same cycle drops the character and sets the overrun tag of the newest stored entry. A push in the same cycle as a pop on a full queue is stored.
- R5: The transmit queue holds 8 characters in order. `tx_data` shows the head, and `tx_count` gives the fill. A push onto a full queue with no pop is ignored, and a pop on an empty queue is ignored.
- R6: FIFO control bits 8:7 select the receive level: 0 selects 1, 1 selects 4, 2 selects 8, 3 selects 12. Status bit 7 is set the cycle after the receive fill count is at or above this level.
- R7: FIFO control bits 4:3 select the transmit level: 0 selects 1, 1 selects 4, 2 or 3 selects 8. Status bit 8 is set the cycle after the number of free transmit entries is at or above this level, but only while the transmit enable (interrupt enable bit 13) is 1.
- R8: Status bit 9 is set when the receive queue is non-empty and below its level, and four `char_tick` pulses have passed with no push arriving.
- R9: Status bits 7, 8 and 9 are sticky. Writing the status-clear register clears each bit whose write data is 0 and keeps each bit whose write data is 1. If the setting condition holds in the same cycle, the bit stays 1.
- R10: `irq` is status bit 8, OR'd with (receive enable, interrupt enable bit 12) AND (status bit 7 OR status bit 9).
- R11: A FIFO control write with bit 1 empties the receive queue, and one with bit 2 empties the transmit queue. Either takes effect only when bit 0 is 1 in the same write.
- R12: A FIFO control write with bit 15 empties both queues and clears the trigger fields, the enables and the sticky bits. `fifo_ctrl[15]` then reads 1 for four cycles and clears itself. While it reads 1, pushes, pops and register writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | Receive shifter delivers a character |
| rx_char | input | 8 | Received character |
| rx_brk | input | 1 | Break tag of the received character |
| rx_fer | input | 1 | Framing-error tag of the received character |
| rx_per | input | 1 | Parity-error tag of the received character |
| rx_pop | input | 1 | Host removes the receive head |
| rx_data | output | 8 | Receive head character |
| tx_push | input | 1 | Host adds a transmit character |
| tx_char | input | 8 | Transmit character |
| tx_pop | input | 1 | Transmit shifter takes the head |
| tx_data | output | 8 | Transmit head character |
| tx_count | output | 4 | Transmit fill count |
| char_tick | input | 1 | One pulse per character time |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 FIFO control, 1 interrupt enable, 2 status clear |
| reg_wdata | input | 16 | Register write data |
| status | output | 16 | Status word |
| fifo_ctrl | output | 16 | FIFO control readback (bit 15 reset busy) |
| irq | output | 1 | Interrupt request |

## Verification
Two events can fall in the same cycle. The first is a host write of 0 to a sticky status bit while that bit's setting condition still holds: the bench clears the receive bit while characters remain queued, and judges that the bit still reads 1 one cycle later. The second is a push and a pop on a full receive queue in the same cycle: the bench checks that the character is stored rather than flagged as overrun, and that it comes out last when the queue drains. A behavioural model built on queues is compared with every output on every cycle throughout.

// File: rtl/uart_fifo_irq_unit.sv
module uart_fifo_irq_unit #(
  parameter int RX_DEPTH     = 16,
  parameter int TX_DEPTH     = 8,
  parameter int DATA_W       = 8,
  parameter int IDLE_CHARS   = 4,
  parameter int SWRST_CYCLES = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rx_push,
  input  logic [DATA_W-1:0]                rx_char,
  input  logic                             rx_brk,
  input  logic                             rx_fer,
  input  logic                             rx_per,
  input  logic                             rx_pop,
  output logic [DATA_W-1:0]                rx_data,
  input  logic                             tx_push,
  input  logic [DATA_W-1:0]                tx_char,
  input  logic                             tx_pop,
  output logic [DATA_W-1:0]                tx_data,
  output logic [$clog2(TX_DEPTH+1)-1:0]    tx_count,
  input  logic                             char_tick,
  input  logic                             reg_we,
  input  logic [1:0]                       reg_sel,
  input  logic [15:0]                      reg_wdata,
  output logic [15:0]                      status,
  output logic [15:0]                      fifo_ctrl,
  output logic                             irq
);
  localparam int RXAW = $clog2(RX_DEPTH);
  localparam int TXAW = $clog2(TX_DEPTH);
  localparam int RXCW = $clog2(RX_DEPTH + 1);
  localparam int TXCW = $clog2(TX_DEPTH + 1);
  localparam int SWW  = $clog2(SWRST_CYCLES + 1);
  localparam int IDW  = $clog2(IDLE_CHARS + 1);
  localparam int EW   = DATA_W + 4;
  localparam logic [1:0] SEL_CTRL = 2'd0, SEL_EN = 2'd1, SEL_STAT = 2'd2;

  logic [EW-1:0]     rx_mem [RX_DEPTH];
  logic [DATA_W-1:0] tx_mem [TX_DEPTH];
  logic [RXAW-1:0]   rx_wp, rx_rp;
  logic [TXAW-1:0]   tx_wp, tx_rp;
  logic [RXCW-1:0]   rx_cnt, rx_lvl;
  logic [TXCW-1:0]   tx_cnt, tx_lvl, tx_free;
  logic [SWW-1:0]    sw_cnt;
  logic [IDW-1:0]    idle;
  logic [1:0]        rx_lvl_sel, tx_lvl_sel;
  logic              tie, rie, rdis, tdis, tout;
  logic              busy, ctrl_wr, en_wr, st_wr, sw_go, wipe;
  logic              rx_clr, tx_clr, rx_full, tx_full;
  logic              rx_enq, rx_deq, rx_ovr, tx_enq, tx_deq, rx_empty;
  logic [EW-1:0]     head;
  logic              wd_unused;

  assign busy    = sw_cnt != '0;
  assign ctrl_wr = reg_we & (reg_sel == SEL_CTRL) & ~busy;
  assign en_wr   = reg_we & (reg_sel == SEL_EN) & ~busy;
  assign st_wr   = reg_we & (reg_sel == SEL_STAT) & ~busy;
  assign sw_go   = ctrl_wr & reg_wdata[15];
  assign wipe    = busy | sw_go;
  assign rx_clr  = wipe | (ctrl_wr & reg_wdata[0] & reg_wdata[1]);
  assign tx_clr  = wipe | (ctrl_wr & reg_wdata[0] & reg_wdata[2]);
  assign wd_unused = ^{reg_wdata[14], reg_wdata[11:10], reg_wdata[6:5]};

  assign rx_full  = rx_cnt == RXCW'(RX_DEPTH);
  assign rx_empty = rx_cnt == '0;
  assign rx_deq   = rx_pop & ~busy & ~rx_empty;
  assign rx_enq   = rx_push & ~busy & (~rx_full | rx_deq);
  assign rx_ovr   = rx_push & ~busy & rx_full & ~rx_deq;
  assign tx_full  = tx_cnt == TXCW'(TX_DEPTH);
  assign tx_deq   = tx_pop & ~busy & (tx_cnt != '0);
  assign tx_enq   = tx_push & ~busy & (~tx_full | tx_deq);
  assign tx_free  = TXCW'(TX_DEPTH) - tx_cnt;

  always_comb begin
    case (rx_lvl_sel)
      2'd0:    rx_lvl = RXCW'(1);
      2'd1:    rx_lvl = RXCW'(4);
      2'd2:    rx_lvl = RXCW'(8);
      default: rx_lvl = RXCW'(12);
    endcase
    case (tx_lvl_sel)
      2'd0:    tx_lvl = TXCW'(1);
      2'd1:    tx_lvl = TXCW'(4);
      default: tx_lvl = TXCW'(8);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_clr) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_enq) rx_wp <= rx_wp + RXAW'(1);
      if (rx_deq) rx_rp <= rx_rp + RXAW'(1);
      case ({rx_enq, rx_deq})
        2'b10:   rx_cnt <= rx_cnt + RXCW'(1);
        2'b01:   rx_cnt <= rx_cnt - RXCW'(1);
        default: rx_cnt <= rx_cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rx_clr && rx_enq)
      rx_mem[rx_wp] <= {rx_brk, rx_fer, rx_per, 1'b0, rx_char};
    else if (!rx_clr && rx_ovr)
      rx_mem[rx_wp - RXAW'(1)][DATA_W] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_clr) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_enq) tx_wp <= tx_wp + TXAW'(1);
      if (tx_deq) tx_rp <= tx_rp + TXAW'(1);
      case ({tx_enq, tx_deq})
        2'b10:   tx_cnt <= tx_cnt + TXCW'(1);
        2'b01:   tx_cnt <= tx_cnt - TXCW'(1);
        default: tx_cnt <= tx_cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!tx_clr && tx_enq) tx_mem[tx_wp] <= tx_char;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_cnt <= '0;
      rx_lvl_sel <= '0; tx_lvl_sel <= '0;
      tie <= 1'b0; rie <= 1'b0;
    end else begin
      if (sw_go) sw_cnt <= SWW'(SWRST_CYCLES);
      else if (busy) sw_cnt <= sw_cnt - SWW'(1);
      if (sw_go) begin
        rx_lvl_sel <= '0; tx_lvl_sel <= '0;
        tie <= 1'b0; rie <= 1'b0;
      end else begin
        if (ctrl_wr) begin
          rx_lvl_sel <= reg_wdata[8:7];
          tx_lvl_sel <= reg_wdata[4:3];
        end
        if (en_wr) begin
          tie <= reg_wdata[13];
          rie <= reg_wdata[12];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdis <= 1'b0; tdis <= 1'b0; tout <= 1'b0;
    end else if (wipe) begin
      rdis <= 1'b0; tdis <= 1'b0; tout <= 1'b0;
    end else begin
      rdis <= (rdis & (~st_wr | reg_wdata[7])) | (rx_cnt >= rx_lvl);
      tdis <= (tdis & (~st_wr | reg_wdata[8])) | (tie & (tx_free >= tx_lvl));
      tout <= (tout & (~st_wr | reg_wdata[9])) |
              ((idle == IDW'(IDLE_CHARS)) & ~rx_empty & (rx_cnt < rx_lvl));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle <= '0;
    else if (rx_clr || rx_empty || (rx_push && !busy)) idle <= '0;
    else if (char_tick && idle != IDW'(IDLE_CHARS)) idle <= idle + IDW'(1);
  end

  assign head      = rx_mem[rx_rp];
  assign rx_data   = head[DATA_W-1:0];
  assign tx_data   = tx_mem[tx_rp];
  assign tx_count  = tx_cnt;
  assign status    = {head[EW-1] & ~rx_empty, rx_empty, head[EW-2] & ~rx_empty,
                      head[EW-3] & ~rx_empty, head[DATA_W] & ~rx_empty, 1'b0,
                      tout, tdis, rdis, 2'b00, 5'(rx_cnt)};
  assign fifo_ctrl = {busy, 6'b0, rx_lvl_sel, 2'b00, tx_lvl_sel, 3'b000};
  assign irq       = tdis | (rie & (rdis | tout));
endmodule

module uart_fifo_irq_unit_chk #(
  parameter int RX_DEPTH = 16,
  parameter int TX_DEPTH = 8,
  parameter int TXCW     = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rx_push,
  input logic            rx_pop,
  input logic            reg_we,
  input logic [15:0]     status,
  input logic [15:0]     fifo_ctrl,
  input logic [TXCW-1:0] tx_count,
  input logic            irq
);
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    status[4:0] <= 5'(RX_DEPTH)); // R2
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= TXCW'(TX_DEPTH)); // R5
  AST_EMPTY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    status[14] |-> (status[15] == 1'b0 && status[13:11] == 3'b000 && status[4:0] == 5'd0)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4:0] == 5'(RX_DEPTH) && rx_push && !rx_pop && !reg_we && !fifo_ctrl[15])
    |=> status[4:0] == 5'(RX_DEPTH)); // R4
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && !reg_we && !fifo_ctrl[15]) |=> status[7]); // R9
  AST_TX_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    status[8] |-> irq); // R10
  AST_SWRST_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_ctrl[15]) |-> (status[4:0] == 5'd0 && tx_count == '0 && !irq)); // R12
endmodule

bind uart_fifo_irq_unit uart_fifo_irq_unit_chk #(
  .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH), .TXCW($clog2(TX_DEPTH + 1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_pop(rx_pop), .reg_we(reg_we),
  .status(status), .fifo_ctrl(fifo_ctrl), .tx_count(tx_count), .irq(irq)
);

// File: tb/uart_fifo_irq_unit_tb.sv
module uart_fifo_irq_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_push, rx_brk, rx_fer, rx_per, rx_pop, tx_push, tx_pop, char_tick, reg_we;
  logic [7:0] rx_char, tx_char, rx_data, tx_data;
  logic [3:0] tx_count;
  logic [1:0] reg_sel;
  logic [15:0] reg_wdata, status, fifo_ctrl;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0, chk_on = 0;

  always #5 clk = ~clk;

  uart_fifo_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_char(rx_char), .rx_brk(rx_brk),
    .rx_fer(rx_fer), .rx_per(rx_per), .rx_pop(rx_pop), .rx_data(rx_data),
    .tx_push(tx_push), .tx_char(tx_char), .tx_pop(tx_pop), .tx_data(tx_data),
    .tx_count(tx_count), .char_tick(char_tick), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .status(status), .fifo_ctrl(fifo_ctrl), .irq(irq));

  // reference model: entry = {brk, fer, per, ovr, char}
  logic [11:0] rxq[$];
  logic [7:0]  txq[$];
  int m_sw, m_idle;
  logic [1:0] m_rt, m_tt;
  bit m_tie, m_rie, m_rd, m_td, m_to;

  function automatic int rlv(logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 12; endcase
  endfunction
  function automatic int tlv(logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 4; default: return 8; endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rxq.delete(); txq.delete();
      m_sw = 0; m_idle = 0; m_rt = 0; m_tt = 0;
      m_tie = 0; m_rie = 0; m_rd = 0; m_td = 0; m_to = 0;
    end else begin
      bit bz, cw, ew, sw, go, rclr, tclr, nr, nt, no, dq;
      int rn, tn;
      logic [11:0] tmp;
      bz = m_sw != 0;
      cw = reg_we && reg_sel == 2'd0 && !bz;
      ew = reg_we && reg_sel == 2'd1 && !bz;
      sw = reg_we && reg_sel == 2'd2 && !bz;
      go = cw && reg_wdata[15];
      rclr = bz || go || (cw && reg_wdata[0] && reg_wdata[1]);
      tclr = bz || go || (cw && reg_wdata[0] && reg_wdata[2]);
      rn = rxq.size(); tn = txq.size();
      nr = ((sw ? (m_rd && reg_wdata[7]) : m_rd) || rn >= rlv(m_rt));
      nt = ((sw ? (m_td && reg_wdata[8]) : m_td) || (m_tie && (8 - tn) >= tlv(m_tt)));
      no = ((sw ? (m_to && reg_wdata[9]) : m_to) || (m_idle == 4 && rn != 0 && rn < rlv(m_rt)));
      if (bz || go) begin m_rd = 0; m_td = 0; m_to = 0; end
      else begin m_rd = nr; m_td = nt; m_to = no; end
      if (rclr || rn == 0 || (rx_push && !bz)) m_idle = 0;
      else if (char_tick && m_idle < 4) m_idle++;
      if (rclr) rxq.delete();
      else begin
        dq = rx_pop && !bz && rn != 0;
        if (dq) void'(rxq.pop_front());
        if (rx_push && !bz) begin
          if (rn < 16 || dq) rxq.push_back({rx_brk, rx_fer, rx_per, 1'b0, rx_char});
          else begin tmp = rxq[rn-1]; tmp[8] = 1'b1; rxq[rn-1] = tmp; end
        end
      end
      if (tclr) txq.delete();
      else begin
        dq = tx_pop && !bz && tn != 0;
        if (dq) void'(txq.pop_front());
        if (tx_push && !bz && (tn < 8 || dq)) txq.push_back(tx_char);
      end
      if (go) begin m_sw = 4; m_rt = 0; m_tt = 0; m_tie = 0; m_rie = 0; end
      else begin
        if (bz) m_sw--;
        if (cw) begin m_rt = reg_wdata[8:7]; m_tt = reg_wdata[4:3]; end
        if (ew) begin m_tie = reg_wdata[13]; m_rie = reg_wdata[12]; end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on && rst_n) begin
      logic [11:0] h;
      bit e;
      e = rxq.size() == 0;
      h = e ? 12'h0 : rxq[0];
      check("R2 rx count", int'(status[4:0]), rxq.size());
      check("R3 R4 head tags", int'(status[15:11]), int'({h[11], e, h[10], h[9], h[8]}));
      if (!e) check("R2 rx head", int'(rx_data), int'(h[7:0]));
      check("R6 rx level bit", int'(status[7]), int'(m_rd));
      check("R7 tx level bit", int'(status[8]), int'(m_td));
      check("R8 timeout bit", int'(status[9]), int'(m_to));
      check("R10 irq", int'(irq), int'(m_td || (m_rie && (m_rd || m_to))));
      check("R5 tx count", int'(tx_count), txq.size());
      if (txq.size() != 0) check("R5 tx head", int'(tx_data), int'(txq[0]));
      check("R12 ctrl readback", int'(fifo_ctrl), int'({m_sw != 0, 6'b0, m_rt, 2'b0, m_tt, 3'b0}));
    end
  end

  task automatic clr_in();
    rx_push = 0; rx_char = 0; rx_brk = 0; rx_fer = 0; rx_per = 0; rx_pop = 0;
    tx_push = 0; tx_char = 0; tx_pop = 0; char_tick = 0;
    reg_we = 0; reg_sel = 0; reg_wdata = 0;
  endtask
  task automatic cyc(); @(negedge clk); clr_in(); endtask
  task automatic push_rx(logic [7:0] c, logic [2:0] f);
    cyc(); rx_push = 1; rx_char = c; {rx_brk, rx_fer, rx_per} = f;
  endtask
  task automatic pop_rx(); cyc(); rx_pop = 1; endtask
  task automatic push_tx(logic [7:0] c); cyc(); tx_push = 1; tx_char = c; endtask
  task automatic pop_tx(); cyc(); tx_pop = 1; endtask
  task automatic wr(logic [1:0] s, logic [15:0] d); cyc(); reg_we = 1; reg_sel = s; reg_wdata = d; endtask
  task automatic tick(); cyc(); char_tick = 1; endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    clr_in();
    repeat (3) @(negedge clk);
    rst_n = 1; chk_on = 1;
    cyc();
    check("R1 status", int'(status), 16'h4000);
    check("R1 ctrl", int'(fifo_ctrl), 0);
    check("R1 tx count", int'(tx_count), 0);
    check("R1 irq", int'(irq), 0);

    // R2 R3 order and tags
    push_rx(8'h41, 3'b000); push_rx(8'h42, 3'b100);
    push_rx(8'h43, 3'b010); push_rx(8'h44, 3'b001);
    cyc(); cyc();
    check("R2 R6 status", int'(status), 16'h0084);
    check("R10 no rx enable", int'(irq), 0);
    pop_rx(); cyc(); check("R3 break", int'(status[15]), 1);
    pop_rx(); cyc(); check("R3 framing", int'(status[13]), 1);
    pop_rx(); cyc(); check("R3 parity", int'(status[12]), 1);
    check("R2 head", int'(rx_data), 8'h44);
    pop_rx(); cyc(); check("R3 empty", int'(status[14]), 1);
    pop_rx(); cyc(); check("R2 empty pop", int'(status[4:0]), 0);
    wr(2'd2, 16'h0000); cyc(); check("R9 clear", int'(status[7]), 0);

    // R4 overrun
    for (int i = 0; i < 16; i++) push_rx(8'(i), 3'b000);
    push_rx(8'hEE, 3'b000);
    cyc(); check("R4 full count", int'(status[4:0]), 16);
    check("R4 head no ovr", int'(status[11]), 0);
    for (int i = 0; i < 15; i++) pop_rx();
    cyc(); check("R4 last data", int'(rx_data), 15);
    check("R4 ovr tag", int'(status[11]), 1);
    pop_rx(); cyc();

    // R4 push with pop while full
    for (int i = 0; i < 16; i++) push_rx(8'(8'h60 + i), 3'b000);
    cyc(); rx_push = 1; rx_pop = 1; rx_char = 8'hAA;
    cyc(); check("R4 simul count", int'(status[4:0]), 16);
    for (int i = 0; i < 15; i++) pop_rx();
    cyc(); check("R4 simul stored", int'(rx_data), 8'hAA);
    check("R4 simul no ovr", int'(status[11]), 0);

    // R9 collision: clear while condition holds
    wr(2'd2, 16'h0000); cyc();
    check("R9 set wins", int'(status[7]), 1);
    pop_rx(); cyc();
    wr(2'd2, 16'h0080); cyc(); check("R9 write one keeps", int'(status[7]), 1);
    wr(2'd2, 16'h0000); cyc(); check("R9 cleared", int'(status[7]), 0);

    // R6 levels, R11 guarded reset
    for (int s = 1; s < 4; s++) begin
      wr(2'd0, 16'(s << 7));
      wr(2'd2, 16'h0000);
      for (int k = 0; k < rlv(2'(s)) - 1; k++) push_rx(8'(k), 3'b000);
      wr(2'd2, 16'h0000); cyc(); cyc();
      check("R6 below level", int'(status[7]), 0);
      push_rx(8'h7F, 3'b000); cyc(); cyc();
      check("R6 at level", int'(status[7]), 1);
      wr(2'd0, 16'(s << 7) | 16'h0006); cyc();
      check("R11 unguarded", int'(status[4:0]), rlv(2'(s)));
      wr(2'd0, 16'(s << 7) | 16'h0003); cyc();
      check("R11 guarded", int'(status[4:0]), 0);
      wr(2'd2, 16'h0000);
    end
    wr(2'd0, 16'h0000);

    // R5 transmit queue
    for (int i = 0; i < 9; i++) push_tx(8'(8'h10 + i));
    cyc(); check("R5 tx full", int'(tx_count), 8);
    check("R5 tx head", int'(tx_data), 8'h10);
    wr(2'd0, 16'h0005); cyc(); check("R11 tx guarded", int'(tx_count), 0);
    for (int i = 0; i < 8; i++) push_tx(8'(8'h10 + i));
    for (int i = 0; i < 7; i++) pop_tx();
    cyc(); check("R5 tx last", int'(tx_data), 8'h17);
    pop_tx(); pop_tx(); cyc(); check("R5 tx empty", int'(tx_count), 0);

    // R7 R10 transmit level
    wr(2'd1, 16'h2000); cyc(); cyc();
    check("R7 tx level", int'(status[8]), 1);
    check("R10 tx irq", int'(irq), 1);
    wr(2'd0, 16'h0010); push_tx(8'h33); wr(2'd2, 16'h0000); cyc();
    check("R7 below level", int'(status[8]), 0);
    pop_tx(); cyc(); cyc();
    check("R7 back at level", int'(status[8]), 1);
    wr(2'd1, 16'h0000); wr(2'd2, 16'h0000); cyc();
    check("R7 disabled", int'(status[8]), 0);
    check("R10 off", int'(irq), 0);

    // R8 timeout
    wr(2'd0, 16'h0080); wr(2'd2, 16'h0000);
    push_rx(8'h55, 3'b000);
    tick(); tick(); tick(); cyc(); cyc();
    check("R8 three ticks", int'(status[9]), 0);
    tick(); cyc(); cyc();
    check("R8 four ticks", int'(status[9]), 1);
    check("R10 rx disabled", int'(irq), 0);
    wr(2'd1, 16'h1000); cyc();
    check("R10 timeout irq", int'(irq), 1);
    pop_rx(); wr(2'd2, 16'h0000); cyc();
    check("R8 cleared", int'(status[9]), 0);

    // R12 software reset
    push_rx(8'h01, 3'b000); push_rx(8'h02, 3'b000); push_tx(8'h03);
    wr(2'd1, 16'h3000);
    wr(2'd0, 16'h8000); cyc();
    check("R12 busy", int'(fifo_ctrl[15]), 1);
    check("R12 rx flushed", int'(status[4:0]), 0);
    check("R12 tx flushed", int'(tx_count), 0);
    push_rx(8'h09, 3'b000);
    cyc(); cyc(); cyc();
    check("R12 self clear", int'(fifo_ctrl), 0);
    check("R12 push ignored", int'(status[4:0]), 0);
    check("R12 enables cleared", int'(irq), 0);

    repeat (20) cyc();
    done = 1;
    finish_run();
  end
endmodule